// File: doc/BRIEF.md
# Transmit Frame Check Sequence Inserter and Checker

This block sits in the transmit path of an Ethernet MAC. Frames arrive on a 64-bit stream, one beat per cycle, with a byte-valid mask and an end-of-frame flag. Each data byte also carries one parity bit that the sender generates. Valid bytes are packed from lane 0 upward. Every beat except the last in a frame is full.

In insert mode the block runs a CRC-32 over the frame and writes the four-byte frame check sequence (FCS) directly after the last valid byte. If that byte leaves fewer than four free lanes, the FCS spills into one extra output beat. In pass-through mode the user supplies the FCS as the last four bytes of the frame. The block forwards those bytes untouched and checks them against the running CRC. It then reports the frame as good, as carrying a bad FCS, or both when the ignore option is set.

Parity is checked on every accepted beat. When the stomp option is on, a frame that held any parity error leaves with its FCS bit-inverted, so the far end will reject it. The three configuration inputs are static: they change only while no frame is in flight.

Top module: `tx_fcs_unit`

## Requirements
- R1: After reset, out_valid and all four status pulses are low and in_ready is high.
- R2: In insert mode the appended FCS is the complement of a CRC-32 computed over the valid bytes. The CRC uses the reflected polynomial 0xEDB88320 and an all-ones start value. The FCS is placed least significant byte first, right after the last valid byte. For the ASCII text "123456789" the appended bytes are 26 39 F4 CB.
- R3: in_keep/out_keep bit i marks byte i (data bits 8i+7..8i) as valid. Valid bytes are contiguous from bit 0, and beats that are not last are full. When an inserted FCS does not fit in the last input beat, which happens when that beat has more than 4 valid bytes, the remaining FCS bytes go out in one extra beat, and that extra beat carries the end flag.
- R4: In pass-through mode the valid bytes, the keep mask and the frame boundaries are forwarded unchanged when no parity stomp applies.
- R5: In pass-through mode, consider a frame whose last four bytes do not equal the FCS of the bytes before them. One cycle after its last beat is accepted, st_fcs_err pulses, and with the ignore option low st_good stays low. A frame with a matching FCS raises st_good instead.
- R6: With cfg_ignore_bad high, a pass-through frame with a wrong FCS raises both st_fcs_err and st_good. In insert mode the ignore option has no effect.
- R7: Parity is even: in_par[i] equals the XOR of the bits of byte i. One cycle after each accepted beat in which any valid byte has wrong parity, st_bad_parity pulses. Parity on invalid lanes is ignored.
- R8: With cfg_par_stomp high, a frame that contains any parity error leaves with its last four bytes (the FCS) bit-inverted, in both modes. Its status is st_fcs_err and st_stomped, without st_good.
- R9: With cfg_par_stomp low, a parity error changes neither the outgoing bytes nor the frame status.
- R10: While out_valid is high and out_ready is low, the output beat holds steady. No beat is lost or duplicated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_insert | input | 1 | 1: compute and append FCS; 0: pass-through and check |
| cfg_ignore_bad | input | 1 | Count bad-FCS pass-through frames as good |
| cfg_par_stomp | input | 1 | Invert the FCS of frames with parity errors |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input bytes, lane 0 in the low bits |
| in_keep | input | DATA_W/8 | Valid mask per byte lane |
| in_par | input | DATA_W/8 | Even parity bit per byte lane |
| in_last | input | 1 | Final beat of the frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the beat |
| out_data | output | DATA_W | Output bytes |
| out_keep | output | DATA_W/8 | Output valid mask per byte lane |
| out_last | output | 1 | Final output beat of the frame |
| st_fcs_err | output | 1 | One-cycle pulse: FCS wrong or stomped |
| st_stomped | output | 1 | One-cycle pulse: FCS inverted because of parity |
| st_good | output | 1 | One-cycle pulse: frame counted as good |
| st_bad_parity | output | 1 | One-cycle pulse per beat with a parity error |

## Verification
The bench builds the block with its default 64-bit width, which gives eight byte lanes. Frame lengths of 1 to 40 bytes then cover every fill level of the final beat. That range reaches the spill threshold between four and five valid bytes in insert mode. In pass-through mode it also reaches the case where the user FCS straddles two beats, so a parity stomp must reach back into a beat the block is still holding. Random output backpressure exercises the two-entry queue at both occupancies.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int          FCS_BYTES   = 4;
    localparam int          FCS_BITS    = 8 * FCS_BYTES;
    localparam logic [31:0] POLY_REFL   = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    // register value left after running over a frame plus its own correct FCS
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? POLY_REFL : 32'h0);
        end
        return r;
    endfunction
endpackage

// File: rtl/fcs_crc_step.sv
module fcs_crc_step #(
    parameter int NB = 8
) (
    input  logic [31:0]     crc_i,
    input  logic [8*NB-1:0] data_i,
    input  logic [NB-1:0]   keep_i,
    output logic [31:0]     crc_o
);
    always_comb begin
        crc_o = crc_i;
        for (int b = 0; b < NB; b++) begin
            if (keep_i[b]) crc_o = fcs_pkg::crc_byte(crc_o, data_i[8*b +: 8]);
        end
    end
endmodule

// File: rtl/fcs_par_check.sv
module fcs_par_check #(
    parameter int NB = 8
) (
    input  logic [8*NB-1:0] data_i,
    input  logic [NB-1:0]   par_i,
    input  logic [NB-1:0]   keep_i,
    output logic [NB-1:0]   bad_o
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign bad_o[i] = keep_i[i] & (par_i[i] ^ (^data_i[8*i +: 8]));
    end
endmodule

// File: rtl/tx_fcs_unit.sv
module tx_fcs_unit #(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_insert,
    input  logic                cfg_ignore_bad,
    input  logic                cfg_par_stomp,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [DATA_W/8-1:0] in_keep,
    input  logic [DATA_W/8-1:0] in_par,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic [DATA_W/8-1:0] out_keep,
    output logic                out_last,
    output logic                st_fcs_err,
    output logic                st_stomped,
    output logic                st_good,
    output logic                st_bad_parity
);
    localparam int NB    = DATA_W / 8;
    localparam int CW    = $clog2(NB + 1);
    localparam int FB    = fcs_pkg::FCS_BYTES;
    localparam int EXT_W = DATA_W + fcs_pkg::FCS_BITS;
    localparam int WIN_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [NB-1:0]     keep;
        logic              last;
    } beat_t;

    typedef struct packed {
        beat_t       q0;       // head of the output queue
        beat_t       q1;
        logic [1:0]  cnt;
        logic [31:0] crc;
        logic        perr;     // parity error seen earlier in this frame
        logic        mid;      // a beat of the current frame was already taken
        logic        fcs_err;
        logic        stomped;
        logic        good;
        logic        bad_par;
    } state_t;

    state_t s_d, s_q;

    logic [31:0]      crc_nx;
    logic [NB-1:0]    lane_bad;
    logic             pop, acc, spill, perr_frame, stomp_now, residue_ok;
    logic [CW-1:0]    nb;
    logic [1:0]       room;
    logic [31:0]      fcs;
    logic [DATA_W-1:0] bmask;
    logic [2*NB-1:0]  wide_keep;
    logic [EXT_W-1:0] ext;
    logic [WIN_W-1:0] win;
    beat_t            beat_a, beat_b;

    fcs_crc_step #(.NB(NB)) u_crc (
        .crc_i (s_q.crc),
        .data_i(in_data),
        .keep_i(in_keep),
        .crc_o (crc_nx)
    );

    fcs_par_check #(.NB(NB)) u_par (
        .data_i(in_data),
        .par_i (in_par),
        .keep_i(in_keep),
        .bad_o (lane_bad)
    );

    always_comb begin
        // pass-through holds a lone non-final beat so a late stomp can still reach it
        out_valid = (s_q.cnt != 2'd0) && (cfg_insert || s_q.q0.last || s_q.cnt == 2'd2);
        out_data  = s_q.q0.data;
        out_keep  = s_q.q0.keep;
        out_last  = s_q.q0.last;
        pop       = out_valid && out_ready;
        room      = s_q.cnt - {1'b0, pop};
        in_ready  = cfg_insert ? (room == 2'd0) : (room <= 2'd1);
        acc       = in_valid && in_ready;

        nb    = '0;
        bmask = '0;
        for (int b = 0; b < NB; b++) begin
            nb               = nb + CW'(in_keep[b]);
            bmask[8*b +: 8]  = {8{in_keep[b]}};
        end
        for (int b = 0; b < 2*NB; b++) begin
            wide_keep[b] = (b < int'(nb) + FB);
        end
        spill      = wide_keep[NB];
        perr_frame = s_q.perr || (|lane_bad);
        stomp_now  = cfg_par_stomp && perr_frame;
        residue_ok = (crc_nx == fcs_pkg::CRC_RESIDUE);
        fcs        = stomp_now ? crc_nx : ~crc_nx;
        ext        = EXT_W'(in_data & bmask) | (EXT_W'(fcs) << (8 * int'(nb)));
        win        = WIN_W'(32'hFFFF_FFFF) << (8 * (int'(nb) + NB - FB));

        beat_a = '{data: in_data, keep: in_keep, last: in_last};
        beat_b = '{data: DATA_W'(ext >> DATA_W), keep: wide_keep[2*NB-1:NB], last: 1'b1};
        if (cfg_insert && in_last) begin
            beat_a.data = ext[DATA_W-1:0];
            beat_a.keep = wide_keep[NB-1:0];
            beat_a.last = !spill;
        end else if (!cfg_insert && in_last && stomp_now) begin
            beat_a.data = beat_a.data ^ win[WIN_W-1:DATA_W];
        end

        s_d         = s_q;
        s_d.fcs_err = 1'b0;
        s_d.stomped = 1'b0;
        s_d.good    = 1'b0;
        s_d.bad_par = 1'b0;
        if (pop) begin
            s_d.q0  = s_q.q1;
            s_d.cnt = s_q.cnt - 2'd1;
        end
        if (acc) begin
            if (!cfg_insert && in_last && stomp_now && s_q.mid) begin
                s_d.q0.data = s_d.q0.data ^ win[DATA_W-1:0];
            end
            if (s_d.cnt == 2'd0) s_d.q0 = beat_a;
            else                 s_d.q1 = beat_a;
            if (cfg_insert && in_last && spill) s_d.q1 = beat_b;
            s_d.cnt = s_d.cnt + 2'd1 + {1'b0, cfg_insert && in_last && spill};

            s_d.bad_par = |lane_bad;
            s_d.crc     = in_last ? fcs_pkg::CRC_SEED : crc_nx;
            s_d.perr    = in_last ? 1'b0 : perr_frame;
            s_d.mid     = !in_last;
            if (in_last) begin
                s_d.fcs_err = (!cfg_insert && !residue_ok) || stomp_now;
                s_d.stomped = stomp_now;
                s_d.good    = !stomp_now && (cfg_insert || residue_ok || cfg_ignore_bad);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.crc <= fcs_pkg::CRC_SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_fcs_err    = s_q.fcs_err;
    assign st_stomped    = s_q.stomped;
    assign st_good       = s_q.good;
    assign st_bad_parity = s_q.bad_par;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last));
    p_keep_packed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_keep[0] && ((out_keep & (out_keep + 1'b1)) == '0));
    p_full_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> &out_keep);
    p_stomp_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_stomped |-> st_fcs_err && !st_good);
    p_status_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_fcs_err || st_good) |-> $past(in_valid && in_ready && in_last));
    p_parity_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_bad_parity |-> $past(in_valid && in_ready));
endmodule

// File: tb/tx_fcs_unit_bench.sv
module tx_fcs_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 64;
    localparam int NB         = DATA_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_insert = 1'b1, cfg_ignore_bad = 1'b0, cfg_par_stomp = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [NB-1:0] in_keep = '0, in_par = '0;
    logic in_ready, out_valid, out_last;
    logic out_ready = 1'b1;
    logic [DATA_W-1:0] out_data;
    logic [NB-1:0] out_keep;
    logic st_fcs_err, st_stomped, st_good, st_bad_parity;

    int n_chk = 0, n_bad = 0;
    int rdy_pct = 100;
    int cur_len = 0;
    int exp_par = 0, seen_par = 0;
    string data_tag = "R4", st_tag = "R5";
    byte unsigned exp_bytes[$];
    int exp_len[$];
    logic [2:0] exp_st[$];

    tx_fcs_unit #(.DATA_W(DATA_W)) u_tx_fcs_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_insert(cfg_insert), .cfg_ignore_bad(cfg_ignore_bad), .cfg_par_stomp(cfg_par_stomp),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_keep(in_keep),
        .in_par(in_par), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
        .out_last(out_last),
        .st_fcs_err(st_fcs_err), .st_stomped(st_stomped), .st_good(st_good),
        .st_bad_parity(st_bad_parity)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always begin
        @(posedge clk);
        #1;
        out_ready = ($urandom_range(99) < rdy_pct);
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] ref_crc(input byte unsigned m[], input int n);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, m[i]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // output monitor, sampled half a period away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                logic [63:0] aw, ew;
                aw = '0;
                ew = '0;
                for (int b = 0; b < NB; b++) begin
                    if (out_keep[b]) begin
                        aw[8*b +: 8] = out_data[8*b +: 8];
                        ew[8*b +: 8] = (exp_bytes.size() != 0) ? exp_bytes.pop_front() : 8'hxx;
                        cur_len++;
                    end
                end
                chk(data_tag, "beat bytes", aw, ew);
                if (out_last) begin
                    chk("R3", "frame length", 64'(cur_len),
                        64'((exp_len.size() != 0) ? exp_len.pop_front() : -1));
                    cur_len = 0;
                end
            end
            if (st_fcs_err || st_good || st_stomped) begin
                chk(st_tag, "status {fcs_err,stomped,good}", {61'h0, st_fcs_err, st_stomped, st_good},
                    {61'h0, (exp_st.size() != 0) ? exp_st.pop_front() : 3'bxxx});
            end
            if (st_bad_parity) seen_par++;
        end
    end

    task automatic xmit(input byte unsigned fr[], input int bad_beat);
        int nbeats;
        nbeats = (fr.size() + NB - 1) / NB;
        for (int k = 0; k < nbeats; k++) begin
            logic [DATA_W-1:0] d;
            logic [NB-1:0] kp, pr;
            bit taken;
            d = '0; kp = '0; pr = '0;
            for (int b = 0; b < NB; b++) begin
                if (k*NB + b < fr.size()) begin
                    d[8*b +: 8] = fr[k*NB + b];
                    kp[b] = 1'b1;
                    pr[b] = ^fr[k*NB + b];
                end else begin
                    pr[b] = $urandom_range(1);   // unkept lanes: arbitrary parity (R7)
                end
            end
            if (k == bad_beat) pr[0] = ~pr[0];
            repeat ($urandom_range(1)) begin @(posedge clk); #1; end
            in_valid = 1'b1; in_data = d; in_keep = kp; in_par = pr; in_last = (k == nbeats-1);
            do begin
                @(negedge clk);
                taken = in_ready;
                @(posedge clk);
                #1;
            end while (!taken);
            in_valid = 1'b0;
        end
    endtask

    task automatic run_frame(input int len, input bit corrupt, input bit perr);
        byte unsigned fr[];
        logic [31:0] c;
        int nbeats, bad_beat;
        bit ps;
        fr = new[len];
        ps = cfg_par_stomp && perr;
        if (cfg_insert) begin
            for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
            c = ref_crc(fr, len);
            if (ps) c = ~c;
            for (int i = 0; i < len; i++) exp_bytes.push_back(fr[i]);
            for (int i = 0; i < 4; i++) exp_bytes.push_back(c[8*i +: 8]);
            exp_len.push_back(len + 4);
        end else begin
            for (int i = 0; i < len - 4; i++) fr[i] = 8'($urandom);
            c = ref_crc(fr, len - 4);
            for (int i = 0; i < 4; i++) fr[len-4+i] = c[8*i +: 8];
            if (corrupt) fr[len-1] = fr[len-1] ^ (8'h01 << $urandom_range(7));
            for (int i = 0; i < len; i++) exp_bytes.push_back((ps && i >= len-4) ? ~fr[i] : fr[i]);
            exp_len.push_back(len);
        end
        exp_st.push_back({(!cfg_insert && corrupt) || ps, ps,
                          !ps && (cfg_insert || !corrupt || cfg_ignore_bad)});
        nbeats = (len + NB - 1) / NB;
        bad_beat = perr ? $urandom_range(nbeats - 1) : -1;
        if (perr) exp_par++;
        xmit(fr, bad_beat);
    endtask

    task automatic drain();
        for (int t = 0; t < 4000 && (exp_bytes.size() != 0 || exp_st.size() != 0); t++) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
        chk(data_tag, "bytes left over", 64'(exp_bytes.size()), 64'd0);
        chk(st_tag, "status left over", 64'(exp_st.size()), 64'd0);
        chk("R7", "parity pulse count", 64'(seen_par), 64'(exp_par));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        byte unsigned kv[];
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk("R1", "status after reset", {60'h0, st_fcs_err, st_stomped, st_good, st_bad_parity}, 64'd0);
        chk("R1", "in_ready after reset", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;

        // R2: known check value for "123456789"
        data_tag = "R2"; st_tag = "R2";
        kv = new[9];
        for (int i = 0; i < 9; i++) kv[i] = 8'h31 + 8'(i);
        for (int i = 0; i < 9; i++) exp_bytes.push_back(kv[i]);
        exp_bytes.push_back(8'h26); exp_bytes.push_back(8'h39);
        exp_bytes.push_back(8'hF4); exp_bytes.push_back(8'hCB);
        exp_len.push_back(13);
        exp_st.push_back(3'b001);
        xmit(kv, -1);
        drain();

        // R3: every final-beat fill level across the spill threshold
        data_tag = "R3"; st_tag = "R3";
        for (int len = 1; len <= 17; len++) run_frame(len, 1'b0, 1'b0);
        drain();

        // R6 + R8 in insert mode: ignore has no effect, parity stomps the appended FCS
        cfg_ignore_bad = 1'b1; cfg_par_stomp = 1'b1; rdy_pct = 60;
        data_tag = "R8"; st_tag = "R6";
        for (int f = 0; f < 40; f++) run_frame($urandom_range(40, 1), 1'b0, $urandom_range(3) == 0);
        drain();

        // R4 + R5: pass-through check, ignore off
        cfg_insert = 1'b0; cfg_ignore_bad = 1'b0; cfg_par_stomp = 1'b0; rdy_pct = 80;
        data_tag = "R4"; st_tag = "R5";
        for (int len = 4; len <= 12; len++) run_frame(len, len[0], 1'b0);
        for (int f = 0; f < 40; f++) run_frame($urandom_range(40, 4), $urandom_range(1), 1'b0);
        drain();

        // R6: ignore high in pass-through
        cfg_ignore_bad = 1'b1;
        st_tag = "R6";
        for (int f = 0; f < 30; f++) run_frame($urandom_range(40, 4), $urandom_range(1), 1'b0);
        drain();

        // R9: parity errors without stomp
        cfg_ignore_bad = 1'b0;
        data_tag = "R9"; st_tag = "R9";
        for (int f = 0; f < 30; f++) run_frame($urandom_range(40, 4), $urandom_range(1), $urandom_range(1));
        drain();

        // R8: stomp in pass-through, including FCS that straddles two beats
        cfg_par_stomp = 1'b1;
        data_tag = "R8"; st_tag = "R8";
        for (int len = 4; len <= 12; len++) run_frame(len, 1'b0, 1'b1);
        for (int f = 0; f < 30; f++) run_frame($urandom_range(40, 4), $urandom_range(1), $urandom_range(1));
        drain();

        // R10: heavy backpressure in both modes
        rdy_pct = 25;
        data_tag = "R10"; st_tag = "R10";
        for (int f = 0; f < 25; f++) run_frame($urandom_range(40, 4), $urandom_range(1), $urandom_range(1));
        drain();
        cfg_insert = 1'b1;
        for (int f = 0; f < 25; f++) run_frame($urandom_range(40, 1), 1'b0, $urandom_range(1));
        drain();

        finish_run();
    end
endmodule